// File: doc/BRIEF.md
# Programmable Input Deglitch Filter

This block cleans a bank of 8-bit digital input ports before the rest of the chip samples them. Software programs one shared stability interval, counted in ticks of a fixed 200 ns time base. It also programs one enable byte per port, with one bit per channel. A channel whose bit is set changes its filtered output only after its raw input has stayed at the new level for the whole programmed interval. A channel whose bit is clear passes its raw input straight through.

The 200 ns time base is generated elsewhere and arrives as a one-cycle `tick` strobe. Configuration is written through a simple write port. One address holds the interval. Each port has its own enable address at `ENABLE_BASE + port`. All enabled channels share the single interval, so rewriting it retimes every channel that is filtering at that moment.

Top module: `deglitch_filter`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `clean_out` equals `raw_in`. Reset clears all enable bits and sets the interval to 0.
- R2: A channel whose enable bit is 0 drives `clean_out` equal to `raw_in` in the same cycle, whatever the interval.
- R3: An enabled channel whose raw input differs from its output takes the raw level on the clock edge of the (N+1)-th tick seen while it differs, where N is the interval. Before that edge the output holds.
- R4: If the raw input of an enabled channel returns to the output level in any cycle, its tick count restarts from zero.
- R5: With an interval of 0, an enabled channel takes a differing raw level on the edge of the next tick.
- R6: Without a `tick` strobe, no enabled channel's output changes, however long its input differs.
- R7: A write to address `INTERVAL_ADDR` (0) stores the low 20 bits of `cfg_wdata`. Bits 31..20 are ignored, so the largest interval is 0xFFFFF ticks.
- R8: The interval is shared and is compared live. Lowering it below the ticks a channel has already counted makes that channel switch on the next tick.
- R9: A write to `ENABLE_BASE + p` (4 + p) sets the enable of port p. Bit i of `cfg_wdata[7:0]` is channel 8p+i, which is `raw_in[8p+i]`. Other ports are untouched. Writes to addresses that map to nothing have no effect.
- R10: Setting a channel's enable bit does not change its output: the output keeps the raw level present when the bit was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle strobe, once per 200 ns |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data |
| raw_in | input | 32 | Raw input channels, port p at bits 8p+7..8p |
| clean_out | output | 32 | Filtered channels, same layout as raw_in |

## Verification
A wrong enable bit shows up in the same cycle. The channel either passes a level it should hold, or holds one it should pass. A stale tick count, or an interval stored from the wrong bits, shows up as a switch one or more ticks early or late. The bench therefore samples the output just before and just after the tick on which a switch is due. A held level that has drifted from the raw input after a disable, or after an enable write, appears at once as an output that differs from `raw_in` without any tick.

// File: rtl/dgf_pkg.sv
// Shared constants and types for the deglitch filter.
// Assumes byte-wide ports and a 32-bit configuration data bus.
package dgf_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned BUS_W  = 32;
    typedef logic [PORT_W-1:0] port_byte_t;
endpackage

// File: rtl/dgf_regs.sv
// Configuration store: one shared interval and one enable byte per port.
// Assumes single-cycle writes. Writes to unmapped addresses are dropped.
module dgf_regs
    import dgf_pkg::*;
#(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned CNT_W         = 20,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned INTERVAL_ADDR = 0,
    parameter int unsigned ENABLE_BASE   = 4,
    localparam int unsigned NUM_CH       = NUM_PORTS * PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [BUS_W-1:0]   cfg_wdata,
    output logic [CNT_W-1:0]   interval_q,
    output logic [NUM_CH-1:0]  enable_q
);
    logic unused_wdata;
    assign unused_wdata = ^cfg_wdata;

    // Capture the low interval bits on a write to the interval address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= '0;
        end else if (cfg_we && cfg_addr == ADDR_W'(INTERVAL_ADDR)) begin
            interval_q <= cfg_wdata[CNT_W-1:0];
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_en
        port_byte_t en_byte;
        // Capture one port's enable byte on a write to its own address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_byte <= '0;
            end else if (cfg_we && cfg_addr == ADDR_W'(ENABLE_BASE + p)) begin
                en_byte <= cfg_wdata[PORT_W-1:0];
            end
        end
        assign enable_q[p*PORT_W +: PORT_W] = en_byte;
    end
endmodule

// File: rtl/dgf_chan.sv
// One filtered channel: holds a level and counts the ticks the raw input
// has differed from it. Assumes the interval may change at any cycle.
module dgf_chan #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic [CNT_W-1:0] interval,
    input  logic             raw,
    output logic             clean
);
    logic             level_q;
    logic [CNT_W-1:0] cnt_q;
    logic             differs;
    logic             expired;

    assign differs = raw != level_q;
    assign expired = cnt_q >= interval;

    // Track the raw level when bypassed, otherwise count stable ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= raw;
            cnt_q   <= '0;
        end else if (!enable) begin
            level_q <= raw;
            cnt_q   <= '0;
        end else if (!differs) begin
            cnt_q   <= '0;
        end else if (tick) begin
            if (expired) begin
                level_q <= raw;
                cnt_q   <= '0;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end

    // Bypass channels pass the raw input, filtered ones the held level.
    always_comb begin
        clean = enable ? level_q : raw;
    end
endmodule

// File: rtl/dgf_port.sv
// One byte-wide port: a row of filtered channels sharing tick and interval.
module dgf_port
    import dgf_pkg::*;
#(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] interval,
    input  port_byte_t       enable,
    input  port_byte_t       raw,
    output port_byte_t       clean
);
    for (genvar i = 0; i < PORT_W; i++) begin : g_ch
        dgf_chan #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .enable   (enable[i]),
            .interval (interval),
            .raw      (raw[i]),
            .clean    (clean[i])
        );
    end
endmodule

// File: rtl/deglitch_filter.sv
// Top of the input deglitch filter: configuration store plus one filter
// row per port. Assumes tick is a one-cycle strobe from a 200 ns base.
module deglitch_filter
    import dgf_pkg::*;
#(
    parameter int unsigned NUM_PORTS     = 4,
    parameter int unsigned CNT_W         = 20,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned INTERVAL_ADDR = 0,
    parameter int unsigned ENABLE_BASE   = 4,
    localparam int unsigned NUM_CH       = NUM_PORTS * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BUS_W-1:0]  cfg_wdata,
    input  logic [NUM_CH-1:0] raw_in,
    output logic [NUM_CH-1:0] clean_out
);
    logic [CNT_W-1:0]  interval_q;
    logic [NUM_CH-1:0] en_vec;

    dgf_regs #(
        .NUM_PORTS     (NUM_PORTS),
        .CNT_W         (CNT_W),
        .ADDR_W        (ADDR_W),
        .INTERVAL_ADDR (INTERVAL_ADDR),
        .ENABLE_BASE   (ENABLE_BASE)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .interval_q (interval_q),
        .enable_q   (en_vec)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dgf_port #(.CNT_W(CNT_W)) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .interval (interval_q),
            .enable   (en_vec[p*PORT_W +: PORT_W]),
            .raw      (raw_in[p*PORT_W +: PORT_W]),
            .clean    (clean_out[p*PORT_W +: PORT_W])
        );
    end
endmodule

// File: rtl/deglitch_filter_chk.sv
// Property checker for the deglitch filter, bound to the top module.
module deglitch_filter_chk #(
    parameter int unsigned NUM_CH        = 32,
    parameter int unsigned CNT_W         = 20,
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned INTERVAL_ADDR = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [31:0]       cfg_wdata,
    input logic [NUM_CH-1:0] raw_in,
    input logic [NUM_CH-1:0] clean_out,
    input logic [CNT_W-1:0]  interval_q,
    input logic [NUM_CH-1:0] en_vec
);
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((~en_vec) & (clean_out ^ raw_in)) == '0);

    p_switch_to_raw_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((clean_out ^ $past(clean_out)) & en_vec & $past(en_vec)
                  & (clean_out ^ $past(raw_in))) == '0);

    p_interval_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && interval_q == '0)
        |=> ((clean_out ^ $past(raw_in)) & en_vec & $past(en_vec)) == '0);

    p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ((clean_out ^ $past(clean_out)) & en_vec & $past(en_vec)) == '0);

    p_interval_low_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == ADDR_W'(INTERVAL_ADDR))
        |=> interval_q == $past(cfg_wdata[CNT_W-1:0]));
endmodule

bind deglitch_filter deglitch_filter_chk #(
    .NUM_CH        (NUM_CH),
    .CNT_W         (CNT_W),
    .ADDR_W        (ADDR_W),
    .INTERVAL_ADDR (INTERVAL_ADDR)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cfg_we     (cfg_we),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .raw_in     (raw_in),
    .clean_out  (clean_out),
    .interval_q (interval_q),
    .en_vec     (en_vec)
);

// File: tb/sim_deglitch_filter.sv
// Scoreboard bench: the driver queues the expected output, the monitor
// pops it at the next falling edge and compares it with clean_out.
module sim_deglitch_filter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] raw_in = '0;
    logic [31:0] clean_out;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;

    always #2 clk = ~clk;

    deglitch_filter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .raw_in    (raw_in),
        .clean_out (clean_out)
    );

    // Monitor: compare each queued expectation with the output.
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            n_run++;
            if (clean_out !== it.exp) begin
                n_fail++;
                $display("FAIL %s: clean_out=%h expected=%h", it.tag, clean_out, it.exp);
            end
        end
    end

    task automatic cycle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [31:0] e, input string tag);
        item_t it;
        it.exp = e;
        it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
        cycle(1);
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [31:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        cycle(1);
        cfg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick = 1'b1;
            cycle(1);
            tick = 1'b0;
        end
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        raw_in = 32'hA5A5_3C3C;
        cycle(3);
        rst_n = 1'b1;
        expect_out(32'hA5A5_3C3C, "R1 after reset");
        raw_in = 32'h1234_5678;
        expect_out(32'h1234_5678, "R2 bypass all");

        write_reg(8'd0, 32'hFFF0_0003);
        write_reg(8'd4, 32'h0000_00FF);
        expect_out(32'h1234_5678, "R10 enable keeps level");
        raw_in = 32'h1234_5687;
        expect_out(32'h1234_5678, "R3 hold before tick");
        ticks(3);
        expect_out(32'h1234_5678, "R7 upper bits ignored, 3 ticks");
        ticks(1);
        expect_out(32'h1234_5687, "R3 switch on 4th tick");

        raw_in = 32'h1234_5600;
        ticks(2);
        raw_in = 32'h1234_5687;
        cycle(1);
        raw_in = 32'h1234_5600;
        ticks(3);
        expect_out(32'h1234_5687, "R4 count restarted");
        ticks(1);
        expect_out(32'h1234_5600, "R4 switch after full run");

        raw_in = 32'h1234_56FF;
        cycle(50);
        expect_out(32'h1234_5600, "R6 no tick no change");

        write_reg(8'd5, 32'h0000_000F);
        raw_in = 32'h1234_A9FF;
        expect_out(32'h1234_A600, "R9 port1 nibble filtered");
        ticks(2);
        write_reg(8'd0, 32'h0000_0001);
        expect_out(32'h1234_A600, "R8 no change on rewrite");
        ticks(1);
        expect_out(32'h1234_A9FF, "R8 shared shorter interval");

        write_reg(8'd0, 32'h0000_0000);
        raw_in = 32'h1234_A93C;
        expect_out(32'h1234_A9FF, "R5 hold before tick");
        ticks(1);
        expect_out(32'h1234_A93C, "R5 one tick latency");

        write_reg(8'h20, 32'h0000_0000);
        write_reg(8'd8, 32'h0000_0000);
        raw_in = 32'h1234_A9C3;
        expect_out(32'h1234_A93C, "R9 unmapped writes ignored");
        ticks(1);
        expect_out(32'h1234_A9C3, "R5 still filtering");

        write_reg(8'd4, 32'h0000_0000);
        raw_in = 32'h1234_A95A;
        expect_out(32'h1234_A95A, "R2 disabled port0");

        write_reg(8'd0, 32'h0010_0002);
        write_reg(8'd7, 32'h0000_0001);
        raw_in = 32'h1334_A95A;
        ticks(2);
        expect_out(32'h1234_A95A, "R7 bit20 dropped, 2 ticks");
        ticks(1);
        expect_out(32'h1334_A95A, "R7 switch on 3rd tick");

        write_reg(8'd0, 32'hFFFF_FFFF);
        raw_in = 32'h1234_A95A;
        ticks(5);
        expect_out(32'h1334_A95A, "R7 max interval holds");
        write_reg(8'd0, 32'h0000_0000);
        ticks(1);
        expect_out(32'h1234_A95A, "R8 interval cut to zero");

        write_reg(8'd4, 32'h0000_00FF);
        write_reg(8'd0, 32'h0000_0005);
        raw_in = 32'h1234_A9A5;
        expect_out(32'h1234_A95A, "R3 hold before reset");
        rst_n = 1'b0;
        cycle(1);
        rst_n = 1'b1;
        expect_out(32'h1234_A9A5, "R1 reset loads raw");
        raw_in = 32'h0F0F_0F0F;
        expect_out(32'h0F0F_0F0F, "R1 enables cleared");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule